// File: doc/BRIEF.md
# Retirement-Triggered Halt Unit

This block sits beside a processor core and watches its retirement stream: one record per retired instruction, carrying the program counter, any load or store the instruction made (address and direction), and an illegal-instruction flag. When a programmed breakpoint or watchpoint matches a retired record, the unit raises a halt request with a cause code. The halt stays up until a resume command arrives. Matching uses retired records only. An instruction that was fetched and then flushed never reaches this port, so speculation cannot cause a false trigger.

The unit halts after the matching instruction has retired. It also raises a pre-state flag, which tells the debug agent to show the machine state from just before that instruction took effect. Out of reset there is an implied breakpoint at the start of the program. The first retirement therefore always halts, so one forward step happens before the first stop. A debug agent that steps backward or forward through a recorded trace presents those trace entries on the same retirement port. The same comparators then evaluate them exactly as they evaluate live retirements.

Configuration uses a small register-write port. That port loads the comparator addresses, writes a control word (enables, watch types, single-step and illegal-halt options) and issues the resume command.

Top module: `retire_trigger_unit`

## Requirements
- R1: After reset, `halt` is 0 and `halt_cause` is 0. Whenever `halt` is 0, `halt_cause` is 0.
- R2: The first retirement after reset halts with cause 1 (breakpoint) and pre-state flag 1, whatever the enables are. Later retirements halt only by comparator or mode.
- R3: A cycle with `ret_valid` low is never evaluated. Its inputs cannot cause a halt, even in single-step mode or with a matching enabled comparator.
- R4: Breakpoint comparator i (addresses 0 to NBP-1 on the configuration port) matches when its enable, control bit 2+i, is set and `ret_pc` equals its address exactly. A disabled comparator never matches. Match gives cause 1.
- R5: Watchpoint j (address 4+j) matches when its enable, control bit 2+NBP+3j, is set, `ret_mem_addr` equals its address, and its type (control bits 3+NBP+3j upward, two bits) admits the direction. Type 01 admits writes, 10 admits reads, 11 admits both, and 00 admits none. Match gives cause 2.
- R6: Cause priority when several apply to one retirement: breakpoint (1) > watchpoint (2) > illegal (3) > single step (4).
- R7: With control bit 1 set, a retirement flagged illegal halts with cause 3. With control bit 1 clear, the illegal flag has no effect.
- R8: With control bit 0 set (single step), every evaluated retirement halts. If nothing of higher priority matches, the cause is 4 and the pre-state flag is 0.
- R9: While halted, `halt`, `halt_cause`, `halt_pc` and the pre-state flag hold, and retirements are ignored. A write of 1 in bit 0 to address 15 (resume) clears `halt` on the next edge.
- R10: `halt` rises on the clock edge that samples the triggering retirement, not before. `halt_pc` then holds that retirement's `ret_pc`, and the pre-state flag is 1 for causes 1 to 3.
- R11: The control word is written at configuration address 8. Comparator addresses are written at 0 to NBP-1 (breakpoints) and 4 to 4+NWP-1 (watchpoints). A write takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | One instruction retired (or trace entry presented) this cycle |
| ret_pc | input | AW | Program counter of the retired instruction |
| ret_illegal | input | 1 | Retired instruction was illegal |
| ret_mem_rd | input | 1 | Retired instruction performed a read |
| ret_mem_wr | input | 1 | Retired instruction performed a write |
| ret_mem_addr | input | AW | Data address of the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | AW | Configuration write data |
| halt | output | 1 | Halt request, held until resume |
| halt_cause | output | 3 | 0 none, 1 breakpoint, 2 watchpoint, 3 illegal, 4 step |
| halt_pc | output | AW | Program counter of the triggering retirement |
| halt_pre_state | output | 1 | Show state from before the triggering instruction |

## Verification
The bench sweeps every breakpoint comparator against every programmed address. A design with crossed comparator wiring, or one that ignores enables, halts on the wrong address. It also sweeps every watchpoint type against no access, a read and a write on each comparator. Swapped type bits show up as halts in the wrong direction, and a mismatch check exposes loose address comparison. Priority is tested by stacking all four causes on one retirement and then removing them one at a time. Three more cases are tested: the forced first halt after reset, retirements that arrive while halted and must not overwrite the captured PC, and invalid cycles that carry matching data.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE = 3'd0,
      CAUSE_BP   = 3'd1,
      CAUSE_WP   = 3'd2,
      CAUSE_ILL  = 3'd3,
      CAUSE_STEP = 3'd4
   } cause_e;

   localparam int unsigned CFG_AW       = 4;
   localparam int unsigned WP_BASE      = 4;
   localparam int unsigned CTRL_ADDR    = 8;
   localparam int unsigned CMD_ADDR     = 15;
   localparam int unsigned CTRL_STEP    = 0;
   localparam int unsigned CTRL_ILL     = 1;
   localparam int unsigned CTRL_BP_LSB  = 2;
   localparam int unsigned MAX_BP       = 4;
   localparam int unsigned MAX_WP       = 4;
endpackage

// File: rtl/rtu_cfg_regs.sv
module rtu_cfg_regs
   import rtu_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned NBP = 4,
   parameter int unsigned NWP = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [CFG_AW-1:0]       cfg_addr,
   input  logic [AW-1:0]           cfg_wdata,
   output logic [NBP-1:0][AW-1:0]  bp_addr,
   output logic [NBP-1:0]          bp_en,
   output logic [NWP-1:0][AW-1:0]  wp_addr,
   output logic [NWP-1:0]          wp_en,
   output logic [NWP-1:0][1:0]     wp_type,
   output logic                    step_en,
   output logic                    ill_en,
   output logic                    resume
);
   localparam int unsigned WP_LSB = CTRL_BP_LSB + NBP;
   localparam int unsigned CTRL_W = WP_LSB + 3 * NWP;

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(CTRL_ADDR))
         ctrl_q <= cfg_wdata[CTRL_W-1:0];
   end

   assign step_en = ctrl_q[CTRL_STEP];
   assign ill_en  = ctrl_q[CTRL_ILL];
   assign resume  = cfg_we && (cfg_addr == CFG_AW'(CMD_ADDR)) && cfg_wdata[0];

   for (genvar i = 0; i < NBP; i++) begin : g_bp_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bp_addr[i] <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(i))
            bp_addr[i] <= cfg_wdata;
      end
      assign bp_en[i] = ctrl_q[CTRL_BP_LSB + i];
   end

   for (genvar j = 0; j < NWP; j++) begin : g_wp_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            wp_addr[j] <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(WP_BASE + j))
            wp_addr[j] <= cfg_wdata;
      end
      assign wp_en[j]   = ctrl_q[WP_LSB + 3*j];
      assign wp_type[j] = ctrl_q[WP_LSB + 3*j + 1 +: 2];
   end
endmodule

// File: rtl/rtu_bp_bank.sv
module rtu_bp_bank #(
   parameter int unsigned AW  = 32,
   parameter int unsigned NBP = 4
) (
   input  logic [AW-1:0]           ret_pc,
   input  logic [NBP-1:0][AW-1:0]  bp_addr,
   input  logic [NBP-1:0]          bp_en,
   output logic                    bp_any
);
   logic [NBP-1:0] hit;

   for (genvar i = 0; i < NBP; i++) begin : g_cmp
      assign hit[i] = bp_en[i] && (ret_pc == bp_addr[i]);
   end

   assign bp_any = |hit;
endmodule

// File: rtl/rtu_wp_bank.sv
module rtu_wp_bank #(
   parameter int unsigned AW  = 32,
   parameter int unsigned NWP = 2
) (
   input  logic [AW-1:0]           mem_addr,
   input  logic                    mem_rd,
   input  logic                    mem_wr,
   input  logic [NWP-1:0][AW-1:0]  wp_addr,
   input  logic [NWP-1:0]          wp_en,
   input  logic [NWP-1:0][1:0]     wp_type,
   output logic                    wp_any
);
   logic [NWP-1:0] hit;

   for (genvar j = 0; j < NWP; j++) begin : g_cmp
      logic dir_ok;
      assign dir_ok = (wp_type[j][0] && mem_wr) || (wp_type[j][1] && mem_rd);
      assign hit[j] = wp_en[j] && dir_ok && (mem_addr == wp_addr[j]);
   end

   assign wp_any = |hit;
endmodule

// File: rtl/rtu_halt_ctl.sv
module rtu_halt_ctl
   import rtu_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ret_valid,
   input  logic [AW-1:0]  ret_pc,
   input  logic           ret_illegal,
   input  logic           bp_any,
   input  logic           wp_any,
   input  logic           ill_en,
   input  logic           step_en,
   input  logic           resume,
   output logic           halt,
   output cause_e         cause,
   output logic [AW-1:0]  cap_pc,
   output logic           pre_state
);
   logic   first_pending;
   cause_e cand;

   always_comb begin
      if (first_pending || bp_any)   cand = CAUSE_BP;
      else if (wp_any)               cand = CAUSE_WP;
      else if (ret_illegal && ill_en) cand = CAUSE_ILL;
      else if (step_en)              cand = CAUSE_STEP;
      else                           cand = CAUSE_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt          <= 1'b0;
         cause         <= CAUSE_NONE;
         cap_pc        <= '0;
         pre_state     <= 1'b0;
         first_pending <= 1'b1;
      end else if (halt) begin
         if (resume) begin
            halt      <= 1'b0;
            cause     <= CAUSE_NONE;
            pre_state <= 1'b0;
         end
      end else if (ret_valid && cand != CAUSE_NONE) begin
         halt          <= 1'b1;
         cause         <= cand;
         cap_pc        <= ret_pc;
         pre_state     <= (cand != CAUSE_STEP);
         first_pending <= 1'b0;
      end
   end
endmodule

// File: rtl/retire_trigger_unit.sv
module retire_trigger_unit
   import rtu_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned NBP = 4,
   parameter int unsigned NWP = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ret_valid,
   input  logic [AW-1:0]  ret_pc,
   input  logic           ret_illegal,
   input  logic           ret_mem_rd,
   input  logic           ret_mem_wr,
   input  logic [AW-1:0]  ret_mem_addr,
   input  logic           cfg_we,
   input  logic [3:0]     cfg_addr,
   input  logic [AW-1:0]  cfg_wdata,
   output logic           halt,
   output logic [2:0]     halt_cause,
   output logic [AW-1:0]  halt_pc,
   output logic           halt_pre_state
);
   localparam int unsigned CTRL_W = CTRL_BP_LSB + NBP + 3 * NWP;

   if (NBP < 1 || NBP > MAX_BP) begin : g_bad_nbp
      $error("NBP must be between 1 and 4");
   end
   if (NWP < 1 || NWP > MAX_WP) begin : g_bad_nwp
      $error("NWP must be between 1 and 4");
   end
   if (AW < CTRL_W) begin : g_bad_aw
      $error("AW too narrow for the control word");
   end

   logic [NBP-1:0][AW-1:0] bp_addr;
   logic [NBP-1:0]         bp_en;
   logic [NWP-1:0][AW-1:0] wp_addr;
   logic [NWP-1:0]         wp_en;
   logic [NWP-1:0][1:0]    wp_type;
   logic                   step_en;
   logic                   ill_en;
   logic                   resume;
   logic                   bp_any;
   logic                   wp_any;
   cause_e                 cause;

   rtu_cfg_regs #(.AW(AW), .NBP(NBP), .NWP(NWP)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .bp_addr   (bp_addr),
      .bp_en     (bp_en),
      .wp_addr   (wp_addr),
      .wp_en     (wp_en),
      .wp_type   (wp_type),
      .step_en   (step_en),
      .ill_en    (ill_en),
      .resume    (resume)
   );

   rtu_bp_bank #(.AW(AW), .NBP(NBP)) u_bp (
      .ret_pc  (ret_pc),
      .bp_addr (bp_addr),
      .bp_en   (bp_en),
      .bp_any  (bp_any)
   );

   rtu_wp_bank #(.AW(AW), .NWP(NWP)) u_wp (
      .mem_addr (ret_mem_addr),
      .mem_rd   (ret_mem_rd),
      .mem_wr   (ret_mem_wr),
      .wp_addr  (wp_addr),
      .wp_en    (wp_en),
      .wp_type  (wp_type),
      .wp_any   (wp_any)
   );

   rtu_halt_ctl #(.AW(AW)) u_halt (
      .clk         (clk),
      .rst_n       (rst_n),
      .ret_valid   (ret_valid),
      .ret_pc      (ret_pc),
      .ret_illegal (ret_illegal),
      .bp_any      (bp_any),
      .wp_any      (wp_any),
      .ill_en      (ill_en),
      .step_en     (step_en),
      .resume      (resume),
      .halt        (halt),
      .cause       (cause),
      .cap_pc      (halt_pc),
      .pre_state   (halt_pre_state)
   );

   assign halt_cause = cause;
endmodule

// File: rtl/rtu_checker.sv
module rtu_checker #(
   parameter int unsigned AW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ret_valid,
   input logic           cfg_we,
   input logic [3:0]     cfg_addr,
   input logic [AW-1:0]  cfg_wdata,
   input logic           step_en,
   input logic           halt,
   input logic [2:0]     halt_cause,
   input logic [AW-1:0]  halt_pc,
   input logic           halt_pre_state
);
   logic resume_cmd;
   assign resume_cmd = cfg_we && (cfg_addr == 4'd15) && cfg_wdata[0];

   // R1
   a_r1_idle_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !halt |-> halt_cause == 3'd0);

   // R9
   a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      halt && !resume_cmd |=> halt && $stable(halt_pc) && $stable(halt_cause));

   // R9
   a_r9_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      halt && resume_cmd |=> !halt);

   // R3
   a_r3_no_halt_without_retire: assert property (@(posedge clk) disable iff (!rst_n)
      !halt && !ret_valid |=> !halt);

   // R8
   a_r8_step_always_halts: assert property (@(posedge clk) disable iff (!rst_n)
      !halt && ret_valid && step_en |=> halt);

   // R10
   a_r10_pre_flag: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (halt_pre_state == (halt_cause != 3'd4)) && halt_cause != 3'd0 && halt_cause <= 3'd4);
endmodule

bind retire_trigger_unit rtu_checker #(.AW(AW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ret_valid      (ret_valid),
   .cfg_we         (cfg_we),
   .cfg_addr       (cfg_addr),
   .cfg_wdata      (cfg_wdata),
   .step_en        (step_en),
   .halt           (halt),
   .halt_cause     (halt_cause),
   .halt_pc        (halt_pc),
   .halt_pre_state (halt_pre_state)
);

// File: tb/retire_trigger_unit_bench.sv
module retire_trigger_unit_bench;
   localparam int unsigned AW  = 32;
   localparam int unsigned NBP = 4;
   localparam int unsigned NWP = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ret_valid = 1'b0;
   logic [AW-1:0]  ret_pc = '0;
   logic           ret_illegal = 1'b0;
   logic           ret_mem_rd = 1'b0;
   logic           ret_mem_wr = 1'b0;
   logic [AW-1:0]  ret_mem_addr = '0;
   logic           cfg_we = 1'b0;
   logic [3:0]     cfg_addr = '0;
   logic [AW-1:0]  cfg_wdata = '0;
   logic           halt;
   logic [2:0]     halt_cause;
   logic [AW-1:0]  halt_pc;
   logic           halt_pre_state;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   retire_trigger_unit #(.AW(AW), .NBP(NBP), .NWP(NWP)) u_retire_trigger_unit (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_illegal(ret_illegal), .ret_mem_rd(ret_mem_rd), .ret_mem_wr(ret_mem_wr),
      .ret_mem_addr(ret_mem_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .halt(halt), .halt_cause(halt_cause),
      .halt_pc(halt_pc), .halt_pre_state(halt_pre_state)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // control word: bit0 step, bit1 illegal, bits2..5 bp enables,
   // wp0 enable bit6, type bits 8:7; wp1 enable bit9, type bits 11:10
   function automatic logic [31:0] mk_ctrl(bit step, bit ill, logic [3:0] bpen,
                                           bit w0e, logic [1:0] w0t,
                                           bit w1e, logic [1:0] w1t);
      return {20'b0, w1t, w1e, w0t, w0e, bpen, ill, step};
   endfunction

   task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic retire(input logic [31:0] pc, input bit rd, input bit wr,
                         input logic [31:0] ma, input bit ill, input bit vld);
      @(negedge clk);
      ret_valid = vld; ret_pc = pc; ret_mem_rd = rd; ret_mem_wr = wr;
      ret_mem_addr = ma; ret_illegal = ill;
      @(negedge clk);
      ret_valid = 1'b0; ret_mem_rd = 1'b0; ret_mem_wr = 1'b0; ret_illegal = 1'b0;
   endtask

   task automatic resume_if_halted();
      if (halt) cfg_write(4'd15, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 halt after reset", halt, 0);
      chk("R1 cause after reset", halt_cause, 0);

      // R10: halt must not appear before the sampling edge
      @(negedge clk);
      ret_valid = 1'b1; ret_pc = 32'h100;
      #1;
      chk("R10 no combinational halt", halt, 0);
      @(negedge clk);
      ret_valid = 1'b0;
      // R2: implicit first-step breakpoint
      chk("R2 first retire halts", halt, 1);
      chk("R2 first retire cause", halt_cause, 1);
      chk("R2 pre-state flag", halt_pre_state, 1);
      chk("R10 captured pc", halt_pc, 32'h100);

      // R9: retirement while halted ignored
      retire(32'h200, 0, 0, 0, 0, 1);
      chk("R9 pc held while halted", halt_pc, 32'h100);
      chk("R9 still halted", halt, 1);
      cfg_write(4'd15, 32'd1);
      chk("R9 resume clears halt", halt, 0);
      chk("R1 cause cleared", halt_cause, 0);

      retire(32'h300, 0, 0, 0, 0, 1);
      chk("R2 later retire without match", halt, 0);

      // R3: invalid cycles with matching data and single step on
      cfg_write(4'd0, 32'h400);
      cfg_write(4'd8, mk_ctrl(1, 0, 4'b0001, 0, 0, 0, 0));
      retire(32'h400, 0, 0, 0, 0, 0);
      chk("R3 invalid cycle ignored", halt, 0);

      // R4 / R11: breakpoint sweep
      for (int i = 0; i < NBP; i++) cfg_write(4'(i), 32'h1000 + 32'(16 * i));
      for (int i = 0; i < NBP; i++) begin
         cfg_write(4'd8, mk_ctrl(0, 0, 4'(1 << i), 0, 0, 0, 0));
         for (int k = 0; k < NBP; k++) begin
            retire(32'h1000 + 32'(16 * k), 0, 0, 0, 0, 1);
            chk($sformatf("R4 bp en=%0d pc=%0d halt", i, k), halt, (i == k) ? 1 : 0);
            if (i == k) chk("R4 bp cause", halt_cause, 1);
            resume_if_halted();
         end
      end
      cfg_write(4'd8, mk_ctrl(0, 0, 4'b0000, 0, 0, 0, 0));
      retire(32'h1000, 0, 0, 0, 0, 1);
      chk("R4 disabled bp no match", halt, 0);

      // R5 / R11: watchpoint type x direction sweep
      cfg_write(4'd4, 32'h8000);
      cfg_write(4'd5, 32'h9000);
      for (int w = 0; w < NWP; w++) begin
         for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 3; d++) begin
               bit rd;
               bit wr;
               bit exp;
               rd = (d == 1);
               wr = (d == 2);
               exp = (rd && t[1]) || (wr && t[0]);
               if (w == 0) cfg_write(4'd8, mk_ctrl(0, 0, 0, 1, 2'(t), 0, 0));
               else        cfg_write(4'd8, mk_ctrl(0, 0, 0, 0, 0, 1, 2'(t)));
               retire(32'h50, rd, wr, (w == 0) ? 32'h8000 : 32'h9000, 0, 1);
               chk($sformatf("R5 wp%0d type%0d dir%0d halt", w, t, d), halt, exp);
               if (exp) chk("R5 wp cause", halt_cause, 2);
               resume_if_halted();
            end
         end
      end
      cfg_write(4'd8, mk_ctrl(0, 0, 0, 1, 2'b11, 0, 0));
      retire(32'h50, 1, 1, 32'h8004, 0, 1);
      chk("R5 address mismatch", halt, 0);

      // R7: illegal flag
      cfg_write(4'd8, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
      retire(32'h60, 0, 0, 0, 1, 1);
      chk("R7 illegal ignored when off", halt, 0);
      cfg_write(4'd8, mk_ctrl(0, 1, 0, 0, 0, 0, 0));
      retire(32'h64, 0, 0, 0, 1, 1);
      chk("R7 illegal halt", halt, 1);
      chk("R7 illegal cause", halt_cause, 3);
      chk("R10 illegal pre-state", halt_pre_state, 1);
      resume_if_halted();

      // R6: priority ladder
      cfg_write(4'd0, 32'h700);
      cfg_write(4'd8, mk_ctrl(1, 1, 4'b0001, 1, 2'b11, 0, 0));
      retire(32'h700, 0, 1, 32'h8000, 1, 1);
      chk("R6 bp over all", halt_cause, 1);
      resume_if_halted();
      retire(32'h704, 0, 1, 32'h8000, 1, 1);
      chk("R6 wp over illegal", halt_cause, 2);
      resume_if_halted();
      retire(32'h708, 0, 0, 0, 1, 1);
      chk("R6 illegal over step", halt_cause, 3);
      resume_if_halted();
      retire(32'h70c, 0, 0, 0, 0, 1);
      chk("R8 step cause", halt_cause, 4);
      chk("R8 step pre-state", halt_pre_state, 0);
      chk("R10 step pc", halt_pc, 32'h70c);
      resume_if_halted();
      chk("R9 resume after step", halt, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule